// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm

This block keeps a 32-bit running count that advances once per prescaled period. Each period is measured in ticks. A tick is either every cycle of the system clock or each rising edge of a slow external reference of about 32.768 kHz. That reference is first brought into the system clock domain through a two-flop synchroniser and an edge detector, so the whole block runs on one clock.

A down-counting prescaler reloads from its programmed value whenever it passes zero. Each reload advances the main count by one and raises a seconds event. A second event fires when the count takes on the value held in the alarm register. Both event flags are sticky and are set whatever the interrupt masks say. The single interrupt output is a registered OR of each flag gated by its own mask.

Software normally writes the registers in this order: the prescaler, then the initial count, then the alarm if one is wanted, and last the control word that starts counting. The count is not reloaded when counting is stopped and started again.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset every register reads back 0 and `irq` is 0.
- R2: Register map on `addr`: 0 is control (bit0 run, bit1 seconds interrupt mask, bit2 alarm interrupt mask, bit3 tick source, where 1 selects the external reference). 1 is the prescaler reload. 2 is the count: a write loads it and a read returns it. 3 is the alarm value. 4 holds the event flags (bit0 seconds, bit1 alarm). Addresses 5 to 7 read 0 and ignore writes. Read data appears on `rdata` after the clock edge that samples `rd_en`.
- R3: With the internal source and run set, the count advances by exactly one every P+1 clock cycles, where P is the prescaler value. A prescaler write restarts the down-count from P.
- R4: The seconds flag is set on every prescaler reload while running, whatever the seconds mask holds.
- R5: The alarm flag is set when the count takes a new value equal to the alarm register, whatever the alarm mask holds.
- R6: `irq` equals (seconds flag AND seconds mask) OR (alarm flag AND alarm mask), registered one cycle later.
- R7: Writing 1 to a flag bit clears that flag, and writing 0 leaves it alone. A hardware set in the same cycle as a clear leaves the flag set.
- R8: A count write takes effect at the next edge and wins over an increment in the same cycle. A loaded value equal to the alarm sets the alarm flag.
- R9: While run is 0, the count and the prescaler hold their values. Setting run again resumes from the held values with no reload.
- R10: With the external source, each rising edge of `ext_ref` after synchronisation is one tick. A held level and a falling edge produce no tick.
- R11: The count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ref | input | 1 | External slow reference, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked event interrupt |

## Verification
Two pairs of actions can fall in the same clock cycle. A software write-1 clear can land on the cycle in which the prescaler reloads and sets the seconds flag. A count load can land on the cycle in which the prescaler would increment the count. The bench tracks the prescaler phase in its own reference model and issues the clear or the load exactly in the reload cycle. It then expects the flag to remain set, and the count to equal the loaded value rather than that value plus one. Beyond these collisions, every cycle's `irq` and every read result are compared against the model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_PSC  = 3'd1,
        RA_CNT  = 3'd2,
        RA_ALM  = 3'd3,
        RA_EVT  = 3'd4
    } rtc_addr_e;

    // bit order fixes the software view: run is bit 0, source select bit 3
    typedef struct packed {
        logic src_ext;
        logic alm_ie;
        logic sec_ie;
        logic run;
    } rtc_ctrl_t;

    localparam int CTRL_W = $bits(rtc_ctrl_t);
    localparam int EVT_SEC_BIT = 0;
    localparam int EVT_ALM_BIT = 1;

endpackage

// File: rtl/rtc_tick_src.sv
module rtc_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ref,
    input  logic sel_ext,
    output logic tick
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[LAST-1:0], ext_ref};
        s_d.prev = s_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // internal source ticks every cycle; external ticks on a synchronised rise
    assign tick = sel_ext ? (s_q.sync[LAST] & ~s_q.prev) : 1'b1;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ld_en,
    input  logic [PSC_W-1:0] ld_val,
    output logic [PSC_W-1:0] reload,
    output logic             wrap
);

    typedef struct packed {
        logic [PSC_W-1:0] reload;
        logic [PSC_W-1:0] down;
    } psc_state_t;

    psc_state_t s_d, s_q;
    logic       advance;

    always_comb begin
        s_d     = s_q;
        advance = run & tick;
        wrap    = advance & (s_q.down == '0);
        if (ld_en) begin
            s_d.reload = ld_val;
            s_d.down   = ld_val;
        end else if (advance) begin
            s_d.down = wrap ? s_q.reload : s_q.down - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reload = s_q.reload;

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld_en,
    input  logic             alm_wr,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] alarm,
    output logic             hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alarm;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       upd;

    always_comb begin
        s_d = s_q;
        upd = ld_en | step;
        if (ld_en)     s_d.cnt = wval;
        else if (step) s_d.cnt = s_q.cnt + 1'b1;
        if (alm_wr)    s_d.alarm = wval;
        // match only when the count takes a new value, against the held alarm
        hit = upd & (s_d.cnt == s_q.alarm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt   = s_q.cnt;
    assign alarm = s_q.alarm;

endmodule

// File: rtl/rtc_evt_regs.sv
module rtc_evt_regs
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              evt_wr,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [CTRL_W-1:0] wbits,
    input  logic              sec_set,
    input  logic              alm_set,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PSC_W-1:0]  psc_reload,
    input  logic [CNT_W-1:0]  alarm,
    output rtc_ctrl_t         ctrl,
    output logic              sec_flag,
    output logic              alm_flag,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        rtc_ctrl_t         ctrl;
        logic              sif;
        logic              aif;
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       clr_sec, clr_alm;

    always_comb begin
        s_d     = s_q;
        clr_sec = evt_wr & wbits[EVT_SEC_BIT];
        clr_alm = evt_wr & wbits[EVT_ALM_BIT];

        if (ctrl_wr) s_d.ctrl = rtc_ctrl_t'(wbits);

        // a hardware set outranks a same-cycle clear
        s_d.sif = (s_q.sif & ~clr_sec) | sec_set;
        s_d.aif = (s_q.aif & ~clr_alm) | alm_set;

        s_d.irq = (s_q.sif & s_q.ctrl.sec_ie) | (s_q.aif & s_q.ctrl.alm_ie);

        if (rd_en) begin
            case (addr)
                RA_CTRL: s_d.rdata = DATA_W'(s_q.ctrl);
                RA_PSC:  s_d.rdata = DATA_W'(psc_reload);
                RA_CNT:  s_d.rdata = DATA_W'(cnt);
                RA_ALM:  s_d.rdata = DATA_W'(alarm);
                RA_EVT:  s_d.rdata = DATA_W'({s_q.aif, s_q.sif});
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl     = s_q.ctrl;
    assign sec_flag = s_q.sif;
    assign alm_flag = s_q.aif;
    assign irq      = s_q.irq;
    assign rdata    = s_q.rdata;

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_ref,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    rtc_ctrl_t        ctrl_q;
    logic             ctrl_wr, psc_wr, cnt_ld, alm_wr, evt_wr;
    logic             tick_en, sec_step, alm_hit;
    logic             sec_flag, alm_flag;
    logic [PSC_W-1:0] psc_reload;
    logic [CNT_W-1:0] cnt_val, alm_val;

    always_comb begin
        ctrl_wr = wr_en & (addr == RA_CTRL);
        psc_wr  = wr_en & (addr == RA_PSC);
        cnt_ld  = wr_en & (addr == RA_CNT);
        alm_wr  = wr_en & (addr == RA_ALM);
        evt_wr  = wr_en & (addr == RA_EVT);
    end

    rtc_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_ref (ext_ref),
        .sel_ext (ctrl_q.src_ext),
        .tick    (tick_en)
    );

    rtc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.run),
        .tick   (tick_en),
        .ld_en  (psc_wr),
        .ld_val (wdata[PSC_W-1:0]),
        .reload (psc_reload),
        .wrap   (sec_step)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (sec_step),
        .ld_en  (cnt_ld),
        .alm_wr (alm_wr),
        .wval   (wdata[CNT_W-1:0]),
        .cnt    (cnt_val),
        .alarm  (alm_val),
        .hit    (alm_hit)
    );

    rtc_evt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .evt_wr     (evt_wr),
        .rd_en      (rd_en),
        .addr       (addr),
        .wbits      (wdata[CTRL_W-1:0]),
        .sec_set    (sec_step),
        .alm_set    (alm_hit),
        .cnt        (cnt_val),
        .psc_reload (psc_reload),
        .alarm      (alm_val),
        .ctrl       (ctrl_q),
        .sec_flag   (sec_flag),
        .alm_flag   (alm_flag),
        .irq        (irq),
        .rdata      (rdata)
    );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt,
    input logic             sif,
    input logic             aif,
    input logic             sim,
    input logic             aim,
    input logic             run,
    input logic             irq
);

    logic ld, clr_s, clr_a;
    assign ld    = wr_en && (addr == 3'd2);
    assign clr_s = wr_en && (addr == 3'd4) && wdata[0];
    assign clr_a = wr_en && (addr == 3'd4) && wdata[1];

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run && !ld) |=> $stable(cnt)) else $error("count moved while stopped"); // R9
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n) ld |=> (cnt == $past(wdata))) else $error("load not applied"); // R8
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n) !ld |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))) else $error("count jumped"); // R3
    AST_STEP_SETS_SEC: assert property (@(posedge clk) disable iff (!rst_n) !ld |=> ((cnt == $past(cnt)) || sif)) else $error("step without seconds flag"); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past((sif && sim) || (aif && aim))) else $error("irq without masked flag"); // R6
    AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sif && !clr_s) |=> sif) else $error("seconds flag dropped"); // R7
    AST_ALM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (aif && !clr_a) |=> aif) else $error("alarm flag dropped"); // R7

endmodule

bind rtc_alarm_top rtc_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata[CNT_W-1:0]),
    .cnt   (cnt_val),
    .sif   (sec_flag),
    .aif   (alm_flag),
    .sim   (ctrl_q.sec_ie),
    .aim   (ctrl_q.alm_ie),
    .run   (ctrl_q.run),
    .irq   (irq)
);

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_ref = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_tot = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #2 clk = ~clk;

    rtc_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_cnt, m_alm, m_rdata;
    logic [15:0] m_psc, m_pscr;
    logic m_run, m_sim, m_aim, m_src, m_sif, m_aif, m_irq, m_rdv;
    logic m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        logic        tk, wr_psc, ld, upd;
        logic [31:0] nc;
        logic [1:0]  clr;
        if (!rst_n) begin
            m_cnt <= 0; m_alm <= 0; m_rdata <= 0; m_psc <= 0; m_pscr <= 0;
            m_run <= 0; m_sim <= 0; m_aim <= 0; m_src <= 0;
            m_sif <= 0; m_aif <= 0; m_irq <= 0; m_rdv <= 0;
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
        end else begin
            m_s1 <= ext_ref; m_s2 <= m_s1; m_s3 <= m_s2;
            tk     = m_src ? (m_s2 && !m_s3) : 1'b1;
            wr_psc = wr_en && addr == 3'd1;
            ld     = wr_en && addr == 3'd2;
            upd    = 1'b0;
            if (wr_psc) begin m_psc <= wdata[15:0]; m_pscr <= wdata[15:0]; end
            else if (m_run && tk) m_psc <= (m_psc == 0) ? m_pscr : m_psc - 1;
            nc = m_cnt;
            if (m_run && tk && m_psc == 0) begin nc = m_cnt + 1; upd = 1'b1; end
            if (ld) begin nc = wdata; upd = 1'b1; end
            m_cnt <= nc;
            if (wr_en && addr == 3'd3) m_alm <= wdata;
            clr = (wr_en && addr == 3'd4) ? wdata[1:0] : 2'b00;
            m_sif <= (m_sif && !clr[0]) || (m_run && tk && m_psc == 0);
            m_aif <= (m_aif && !clr[1]) || (upd && nc == m_alm);
            m_irq <= (m_sif && m_sim) || (m_aif && m_aim);
            if (wr_en && addr == 3'd0) begin
                m_run <= wdata[0]; m_sim <= wdata[1]; m_aim <= wdata[2]; m_src <= wdata[3];
            end
            m_rdv <= rd_en;
            if (rd_en) begin
                case (addr)
                    3'd0: m_rdata <= {28'd0, m_src, m_aim, m_sim, m_run};
                    3'd1: m_rdata <= {16'd0, m_pscr};
                    3'd2: m_rdata <= m_cnt;
                    3'd3: m_rdata <= m_alm;
                    3'd4: m_rdata <= {30'd0, m_aif, m_sif};
                    default: m_rdata <= 0;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq === m_irq, "R6", {31'd0, irq}, {31'd0, m_irq});
            if (m_rdv) chk(rdata === m_rdata, cur_req, rdata, m_rdata);
        end
    end

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_reload_slot();
        while (!(m_run && !m_src && m_psc == 0)) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tot++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (4) @(negedge clk);
        chk(irq === 1'b0, "R1", {31'd0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of all registers
        cur_req = "R1";
        for (int a = 0; a < 5; a++) begin
            bus_rd(a[2:0], v);
            chk(v === 0, "R1", v, 0);
        end

        // R2: map, field readback, unused address
        cur_req = "R2";
        bus_wr(3'd0, 32'h0000_000E);
        bus_rd(3'd0, v); chk(v === 32'hE, "R2", v, 32'hE);
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd5, 32'hFFFF_FFFF);
        bus_rd(3'd5, v); chk(v === 0, "R2", v, 0);
        bus_wr(3'd3, 32'h1234_5678);
        bus_rd(3'd3, v); chk(v === 32'h1234_5678, "R2", v, 32'h1234_5678);

        // R3: period P+1 with internal ticks
        cur_req = "R3";
        bus_wr(3'd3, 32'hFFFF_0000);
        bus_wr(3'd1, 32'd4);
        bus_wr(3'd2, 32'd0);
        bus_wr(3'd4, 32'h3);
        bus_wr(3'd0, 32'h1);
        idle(7);
        bus_rd(3'd2, v);
        idle(24);
        bus_rd(3'd2, v2);
        chk(v2 - v === 32'd5, "R3", v2 - v, 32'd5);

        // R4/R5: flags set with masks clear, no interrupt
        cur_req = "R5";
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd1, 32'd1);
        bus_wr(3'd2, 32'd20);
        bus_wr(3'd3, 32'd22);
        bus_wr(3'd4, 32'h3);
        bus_wr(3'd0, 32'h1);
        idle(10);
        bus_rd(3'd4, v);
        chk(v === 32'h3, "R4", v, 32'h3);
        chk(irq === 1'b0, "R5", {31'd0, irq}, 0);

        // R6: masks gate the interrupt
        cur_req = "R6";
        bus_wr(3'd0, 32'h3);
        idle(2);
        chk(irq === 1'b1, "R6", {31'd0, irq}, 1);
        bus_wr(3'd0, 32'h0);
        idle(2);
        chk(irq === 1'b0, "R6", {31'd0, irq}, 0);
        bus_wr(3'd0, 32'h4);
        idle(2);
        chk(irq === 1'b1, "R6", {31'd0, irq}, 1);

        // R7: writing 0 keeps flags, writing 1 clears
        cur_req = "R7";
        bus_wr(3'd4, 32'h0);
        bus_rd(3'd4, v); chk(v === 32'h3, "R7", v, 32'h3);
        bus_wr(3'd4, 32'h2);
        bus_rd(3'd4, v); chk(v[1] === 1'b0, "R7", v, 32'h1);
        idle(2);
        chk(irq === 1'b0, "R7", {31'd0, irq}, 0);

        // R7: clear collides with a reload, set wins
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd1, 32'd7);
        bus_wr(3'd4, 32'h3);
        bus_wr(3'd0, 32'h1);
        wait_reload_slot();
        bus_wr(3'd4, 32'h1);
        bus_rd(3'd4, v); chk(v[0] === 1'b1, "R7", v, 32'h1);

        // R8: load collides with an increment, load wins
        cur_req = "R8";
        wait_reload_slot();
        bus_wr(3'd2, 32'd100);
        bus_rd(3'd2, v); chk(v === 32'd100, "R8", v, 32'd100);
        // R8: load equal to alarm sets the alarm flag
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd3, 32'd555);
        bus_wr(3'd4, 32'h3);
        bus_wr(3'd2, 32'd555);
        bus_rd(3'd4, v); chk(v === 32'h2, "R8", v, 32'h2);

        // R9: stop holds, restart resumes
        cur_req = "R9";
        bus_wr(3'd2, 32'd40);
        bus_wr(3'd0, 32'h1);
        idle(13);
        bus_wr(3'd0, 32'h0);
        bus_rd(3'd2, v);
        idle(40);
        bus_rd(3'd2, v2);
        chk(v2 === v, "R9", v2, v);
        bus_wr(3'd0, 32'h1);
        idle(20);
        bus_rd(3'd2, v2);
        chk(v2 > v && v2 < v + 4, "R9", v2, v + 2);

        // R10: external reference edges
        cur_req = "R10";
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd1, 32'd0);
        bus_wr(3'd2, 32'd0);
        bus_wr(3'd0, 32'h9);
        idle(4);
        for (int p = 0; p < 5; p++) begin
            ext_ref = 1'b1; idle(4);
            ext_ref = 1'b0; idle(4);
        end
        idle(4);
        bus_rd(3'd2, v); chk(v === 32'd5, "R10", v, 32'd5);
        ext_ref = 1'b1;
        idle(20);
        bus_rd(3'd2, v); chk(v === 32'd6, "R10", v, 32'd6);
        ext_ref = 1'b0;
        idle(4);

        // R11: wrap to zero hits a zero alarm
        cur_req = "R11";
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd3, 32'd0);
        bus_wr(3'd2, 32'hFFFF_FFFF);
        bus_wr(3'd4, 32'h3);
        bus_wr(3'd0, 32'h5);
        idle(1);
        bus_rd(3'd4, v); chk(v[1] === 1'b1, "R11", v, 32'h3);
        bus_rd(3'd2, v); chk(v < 32'd8, "R11", v, 32'd3);
        idle(2);
        chk(irq === 1'b1, "R11", {31'd0, irq}, 1);

        bus_wr(3'd0, 32'h0);
        idle(3);
        done = 1'b1;
        report();
        $finish;
    end

endmodule